// File: doc/BRIEF.md
# Floating-Point Condition Branch Resolver

This block resolves conditional branches that test a floating-point condition bit. It decodes the fetched instruction word and checks whether the word is a coprocessor-1 condition branch. For such a word it picks one of eight condition bits and compares that bit with the branch sense, which selects branch-on-true or branch-on-false. It then forms the PC-relative destination and reports three things: whether to redirect, where control goes next, and whether the delay-slot instruction must be squashed.

The block holds the condition bits in its own register. The floating-point compare unit updates that register one bit per cycle through a write port. A write made in the same cycle as a branch evaluation is forwarded, so the branch sees the new value. A "likely" flag in the instruction makes a not-taken branch squash its delay slot.

A build-time legacy option limits the block to condition bit 0. A delay-slot word that is itself a control-transfer instruction has no defined behaviour, and the block reports it on a separate error output.

Top module: `fpbr_resolve`

## Requirements
- R1: `br_hit` is 1 exactly when `in_valid` is 1, `instr[31:26]` is 6'b010001 and `instr[25:21]` is 5'b01000. With `br_hit` at 0, `br_taken`, `nullify_slot`, `rsv_enc` and `slot_err` are all 0.
- R2: `br_target` equals `pc + 4 + sext(instr[15:0] << 2)`, where the shifted value is an 18-bit signed byte displacement widened to the address width, and the sum wraps modulo 2^AW.
- R3: On a hit, `br_taken` is 1 when the condition bit chosen by `instr[20:18]` equals the sense bit `instr[16]`. Sense 1 branches on a set bit and sense 0 branches on a clear bit.
- R4: `next_pc` equals `br_target` when `br_taken` is 1, and `pc + 4` otherwise, including when there is no hit.
- R5: `nullify_slot` is 1 only on a hit with the likely bit `instr[17]` at 1 and the branch not taken. A taken branch never squashes its slot.
- R6: After reset all condition bits are 0. On a clock edge with `cmp_we` at 1, bit `cmp_idx` takes the value `cmp_val` and the other bits keep their values. The register is visible on `cc_state`.
- R7: While `cmp_we` is 1, a branch evaluated in that same cycle uses `cmp_val` for bit `cmp_idx`.
- R8: With LEGACY=1, the resolver always tests bit 0, whatever `instr[20:18]` holds, and `rsv_enc` is 1 on a hit whose `instr[20:18]` is nonzero. With LEGACY=0, `rsv_enc` stays 0.
- R9: On a hit, `slot_err` is 1 when `slot_instr` is a control transfer. That means any of: `slot_instr[31:26]` in 6'b000001..6'b000111; `slot_instr[31:26]` in 6'b010100..6'b010111; opcode 6'b010001 with `slot_instr[25:21]` = 5'b01000; or opcode 6'b000000 with `slot_instr[5:0]` of 6'b001000 or 6'b001001.
- R10: The extreme offsets reach exactly `pc + 4 - 131072` (offset 16'h8000) and `pc + 4 + 131068` (offset 16'h7FFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Fetched instruction word |
| pc | input | AW | Address of the instruction word |
| slot_instr | input | 32 | Instruction word in the delay slot |
| cmp_we | input | 1 | Compare result write enable |
| cmp_idx | input | 3 | Condition bit written by the compare |
| cmp_val | input | 1 | Compare result value |
| br_hit | output | 1 | Word is a condition branch |
| br_taken | output | 1 | Branch condition holds |
| br_target | output | AW | PC-relative destination |
| next_pc | output | AW | Address control moves to |
| nullify_slot | output | 1 | Squash the delay-slot instruction |
| rsv_enc | output | 1 | Reserved condition field in legacy mode |
| slot_err | output | 1 | Control transfer found in delay slot |
| cc_state | output | CCN | Current condition bit register |

## Verification
The assertions check on every cycle:
- that a write lands in the named bit and leaves the other bits alone;
- that squash and redirect never occur together;
- that a non-branch word passes `pc + 4` through;
- that a same-cycle write decides the branch outcome;
- that the reserved flag only appears on a hit.

The bench covers the behaviour that needs stimulus and arithmetic. It loads all 256 condition patterns and evaluates every bit select, sense and likely combination against a reference computed in the bench. It also checks the displacement sums at the range limits, sweeps the delay-slot classification across all 64 opcodes, and compares the legacy-mode instance, which ignores the select field.

// File: rtl/fpbr_pkg.sv
package fpbr_pkg;

   localparam logic [5:0] OPC_FPU     = 6'b010001;
   localparam logic [4:0] SUB_CONDBR  = 5'b01000;
   localparam logic [5:0] OPC_REGFN   = 6'b000000;
   localparam logic [5:0] FN_REGJMP   = 6'b001000;
   localparam logic [5:0] FN_REGJMPLK = 6'b001001;

   typedef struct packed {
      logic        hit;
      logic [2:0]  ccf;
      logic        likely;
      logic        sense;
      logic [15:0] off;
   } br_fields_t;

endpackage

// File: rtl/fpbr_decode.sv
module fpbr_decode
   import fpbr_pkg::*;
(
   input  logic        valid,
   input  logic [31:0] word,
   output br_fields_t  fld
);
   always_comb begin
      fld.hit    = valid && (word[31:26] == OPC_FPU) && (word[25:21] == SUB_CONDBR);
      fld.ccf    = word[20:18];
      fld.likely = word[17];
      fld.sense  = word[16];
      fld.off    = word[15:0];
   end
endmodule

// File: rtl/fpbr_slotcls.sv
module fpbr_slotcls
   import fpbr_pkg::*;
(
   input  logic [5:0] opc,
   input  logic [4:0] sub,
   input  logic [5:0] fn,
   output logic       is_xfer
);
   logic imm_br, likely_br, fpu_br, reg_jmp;

   always_comb begin
      imm_br    = (opc >= 6'b000001) && (opc <= 6'b000111);
      likely_br = (opc[5:2] == 4'b0101);
      fpu_br    = (opc == OPC_FPU) && (sub == SUB_CONDBR);
      reg_jmp   = (opc == OPC_REGFN) && ((fn == FN_REGJMP) || (fn == FN_REGJMPLK));
      is_xfer   = imm_br || likely_br || fpu_br || reg_jmp;
   end
endmodule

// File: rtl/fpbr_ccreg.sv
module fpbr_ccreg #(
   parameter int CCN = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [2:0]     widx,
   input  logic           wval,
   input  logic [2:0]     sel,
   output logic [CCN-1:0] cc_q,
   output logic           sel_bit
);
   localparam int PADW = 8;

   logic [CCN-1:0]  cc_nxt;
   logic [PADW-1:0] fwd_pad;
   logic [PADW-1:0] q_pad;

   generate
      if (CCN < 1 || CCN > PADW) begin : g_bad_ccn
         $error("fpbr_ccreg: CCN must lie in 1..8");
      end
   endgenerate

   for (genvar g = 0; g < CCN; g++) begin : g_bit
      always_comb cc_nxt[g] = (we && (widx == 3'(g))) ? wval : cc_q[g];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cc_q[g] <= 1'b0;
         else        cc_q[g] <= cc_nxt[g];
      end
   end

   always_comb begin
      fwd_pad = '0;
      q_pad   = '0;
      fwd_pad[CCN-1:0] = cc_nxt;
      q_pad[CCN-1:0]   = cc_q;
      sel_bit = fwd_pad[sel];
   end

   // R6: a write lands in the named bit
   p_cc_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && ({1'b0, widx} < 4'(CCN))) |=> (q_pad[$past(widx)] == $past(wval)));

   // R6: no write, no change
   p_cc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cc_q));
endmodule

// File: rtl/fpbr_target.sv
module fpbr_target #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] pc,
   input  logic [15:0]   off,
   output logic [AW-1:0] seq,
   output logic [AW-1:0] dest
);
   localparam int DW = 18;
   localparam int XW = AW - DW;

   logic [AW-1:0] disp;

   generate
      if (AW < DW + 1 || AW > 64) begin : g_bad_aw
         $error("fpbr_target: AW must lie in 19..64");
      end
   endgenerate

   always_comb begin
      disp = {{XW{off[15]}}, off, 2'b00};
      seq  = pc + AW'(4);
      dest = seq + disp;
   end
endmodule

// File: rtl/fpbr_resolve.sv
module fpbr_resolve
   import fpbr_pkg::*;
#(
   parameter int AW     = 32,
   parameter int CCN    = 8,
   parameter bit LEGACY = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [31:0]    instr,
   input  logic [AW-1:0]  pc,
   input  logic [31:0]    slot_instr,
   input  logic           cmp_we,
   input  logic [2:0]     cmp_idx,
   input  logic           cmp_val,
   output logic           br_hit,
   output logic           br_taken,
   output logic [AW-1:0]  br_target,
   output logic [AW-1:0]  next_pc,
   output logic           nullify_slot,
   output logic           rsv_enc,
   output logic           slot_err,
   output logic [CCN-1:0] cc_state
);
   br_fields_t    fld;
   logic [2:0]    sel_idx;
   logic          sel_bit;
   logic          cond;
   logic          slot_xfer;
   logic [AW-1:0] seq_pc;
   logic          unused_slot_bits;

   assign unused_slot_bits = ^slot_instr[20:6];

   fpbr_decode u_dec (
      .valid (in_valid),
      .word  (instr),
      .fld   (fld)
   );

   generate
      if (LEGACY) begin : g_legacy
         assign sel_idx = 3'd0;
         assign rsv_enc = fld.hit && (fld.ccf != 3'd0);
      end else begin : g_full
         assign sel_idx = fld.ccf;
         assign rsv_enc = 1'b0;
      end
   endgenerate

   fpbr_ccreg #(.CCN(CCN)) u_cc (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cmp_we),
      .widx    (cmp_idx),
      .wval    (cmp_val),
      .sel     (sel_idx),
      .cc_q    (cc_state),
      .sel_bit (sel_bit)
   );

   fpbr_target #(.AW(AW)) u_tgt (
      .pc   (pc),
      .off  (fld.off),
      .seq  (seq_pc),
      .dest (br_target)
   );

   fpbr_slotcls u_slot (
      .opc     (slot_instr[31:26]),
      .sub     (slot_instr[25:21]),
      .fn      (slot_instr[5:0]),
      .is_xfer (slot_xfer)
   );

   always_comb begin
      br_hit       = fld.hit;
      cond         = (sel_bit == fld.sense);
      br_taken     = fld.hit && cond;
      next_pc      = br_taken ? br_target : seq_pc;
      nullify_slot = fld.hit && fld.likely && !cond;
      slot_err     = fld.hit && slot_xfer;
   end

   // R5: squash and redirect are exclusive
   p_null_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      nullify_slot |-> !br_taken);

   // R1 / R4: non-branch words pass straight through
   p_nohit_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !br_hit |-> (next_pc == pc + AW'(4)) && !br_taken && !nullify_slot && !slot_err);

   // R7: a same-cycle compare write decides the outcome
   p_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (br_hit && cmp_we && (cmp_idx == sel_idx) && ({1'b0, cmp_idx} < 4'(CCN)))
         |-> (br_taken == (cmp_val == instr[16])));

   // R8: reserved flag only on a hit
   p_rsv_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_enc |-> br_hit);

   // R4: redirect follows the target
   p_taken_tgt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> (next_pc == br_target));
endmodule

// File: tb/fpbr_resolve_tb.sv
module fpbr_resolve_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int CCN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [AW-1:0] pc = '0;
   logic [31:0] slot_instr = '0;
   logic cmp_we = 1'b0;
   logic [2:0] cmp_idx = '0;
   logic cmp_val = 1'b0;

   logic br_hit, br_taken, nullify_slot, rsv_enc, slot_err;
   logic [AW-1:0] br_target, next_pc;
   logic [CCN-1:0] cc_state;
   logic l_hit, l_taken, l_null, l_rsv, l_serr;
   logic [AW-1:0] l_target, l_next;
   logic [CCN-1:0] l_cc;

   int errors = 0;
   int checks = 0;
   logic [7:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpbr_resolve #(.AW(AW), .CCN(CCN), .LEGACY(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
      .slot_instr(slot_instr), .cmp_we(cmp_we), .cmp_idx(cmp_idx), .cmp_val(cmp_val),
      .br_hit(br_hit), .br_taken(br_taken), .br_target(br_target), .next_pc(next_pc),
      .nullify_slot(nullify_slot), .rsv_enc(rsv_enc), .slot_err(slot_err),
      .cc_state(cc_state));

   fpbr_resolve #(.AW(AW), .CCN(CCN), .LEGACY(1'b1)) u_leg (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
      .slot_instr(slot_instr), .cmp_we(cmp_we), .cmp_idx(cmp_idx), .cmp_val(cmp_val),
      .br_hit(l_hit), .br_taken(l_taken), .br_target(l_target), .next_pc(l_next),
      .nullify_slot(l_null), .rsv_enc(l_rsv), .slot_err(l_serr),
      .cc_state(l_cc));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_br(input logic [2:0] cc, input logic nd,
                                        input logic tf, input logic [15:0] off);
      return {6'b010001, 5'b01000, cc, nd, tf, off};
   endfunction

   function automatic logic [AW-1:0] exp_tgt(input logic [AW-1:0] p, input logic [15:0] off);
      return p + 32'd4 + {{14{off[15]}}, off, 2'b00};
   endfunction

   function automatic logic exp_xfer(input logic [31:0] w);
      logic [5:0] o;
      o = w[31:26];
      if (o >= 6'd1 && o <= 6'd7) return 1'b1;
      if (o >= 6'd20 && o <= 6'd23) return 1'b1;
      if (o == 6'd17 && w[25:21] == 5'd8) return 1'b1;
      if (o == 6'd0 && (w[5:0] == 6'd8 || w[5:0] == 6'd9)) return 1'b1;
      return 1'b0;
   endfunction

   task automatic wr(input int idx, input logic v);
      @(negedge clk);
      cmp_we = 1'b1; cmp_idx = 3'(idx); cmp_val = v;
      @(posedge clk); #1;
      cmp_we = 1'b0;
      model[idx] = v;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R6 reset state, R1 idle outputs
      chk("R6 reset cc", 64'(cc_state), 64'h0);
      chk("R1 idle hit", 64'(br_hit), 64'h0);
      chk("R4 idle next", 64'(next_pc), 64'h4);

      // R1: near misses in opcode, sub-op and valid
      pc = 32'h0000_1000;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         slot_instr = {6'b000010, 26'h0};
         case (k)
            0: begin in_valid = 1'b0; instr = mk_br(3'd0, 1'b1, 1'b0, 16'h10); end
            1: begin in_valid = 1'b1; instr = {6'b010000, 5'b01000, 21'h30010}; end
            2: begin in_valid = 1'b1; instr = {6'b010001, 5'b01001, 21'h30010}; end
            default: begin in_valid = 1'b1; instr = {6'b010001, 5'b00000, 21'h30010}; end
         endcase
         #1;
         chk("R1 miss hit", 64'(br_hit), 64'h0);
         chk("R5 miss null", 64'(nullify_slot), 64'h0);
         chk("R9 miss slot", 64'(slot_err), 64'h0);
         chk("R4 miss next", 64'(next_pc), 64'h1004);
      end

      // R3 R4 R5 R6 R8 R2: exhaustive condition patterns
      slot_instr = 32'h0;
      for (int pat = 0; pat < 256; pat++) begin
         for (int b = 0; b < 8; b++) wr(b, 1'(pat >> b));
         chk("R6 cc load", 64'(cc_state), 64'(pat));
         @(negedge clk);
         in_valid = 1'b1;
         for (int c = 0; c < 8; c++) begin
            for (int tf = 0; tf < 2; tf++) begin
               for (int nd = 0; nd < 2; nd++) begin
                  logic [15:0] off;
                  logic ex_t, lx_t;
                  off = 16'(pat * 263 + c * 4099 + tf * 77 + nd);
                  pc  = 32'(pat * 65536 + c * 256 + 32'h4000_0000);
                  instr = mk_br(3'(c), 1'(nd), 1'(tf), off);
                  #1;
                  ex_t = (model[c] == 1'(tf));
                  lx_t = (model[0] == 1'(tf));
                  chk("R1 hit", 64'(br_hit), 64'h1);
                  chk("R3 taken", 64'(br_taken), 64'(ex_t));
                  chk("R2 target", 64'(br_target), 64'(exp_tgt(pc, off)));
                  chk("R4 next", 64'(next_pc), 64'(ex_t ? exp_tgt(pc, off) : pc + 32'd4));
                  chk("R5 nullify", 64'(nullify_slot), 64'(nd == 1 && !ex_t));
                  chk("R8 legacy taken", 64'(l_taken), 64'(lx_t));
                  chk("R8 legacy rsv", 64'(l_rsv), 64'(c != 0));
                  chk("R8 full rsv", 64'(rsv_enc), 64'h0);
               end
            end
         end
      end

      // R7: same-cycle forwarding, both polarities
      for (int v = 0; v < 2; v++) begin
         wr(3, 1'(~v));
         @(negedge clk);
         pc = 32'h0000_2000;
         instr = mk_br(3'd3, 1'b1, 1'b1, 16'h0020);
         cmp_we = 1'b1; cmp_idx = 3'd3; cmp_val = 1'(v);
         #1;
         chk("R7 fwd taken", 64'(br_taken), 64'(v));
         chk("R7 fwd null", 64'(nullify_slot), 64'(v == 0));
         @(posedge clk); #1;
         cmp_we = 1'b0;
         model[3] = 1'(v);
         chk("R6 after fwd", 64'(cc_state), 64'(model));
      end

      // R10: range extremes
      @(negedge clk);
      pc = 32'h0010_0000;
      instr = mk_br(3'd0, 1'b0, 1'b0, 16'h8000);
      #1;
      chk("R10 min", 64'(br_target), 64'(32'h0010_0004 - 32'd131072));
      instr = mk_br(3'd0, 1'b0, 1'b0, 16'h7FFF);
      #1;
      chk("R10 max", 64'(br_target), 64'(32'h0010_0004 + 32'd131068));
      pc = 32'hFFFF_FFF0;
      instr = mk_br(3'd0, 1'b0, 1'b0, 16'h0010);
      #1;
      chk("R2 wrap", 64'(br_target), 64'(32'h0000_0034));

      // R9: delay-slot classification over all opcodes
      pc = 32'h0000_3000;
      instr = mk_br(3'd1, 1'b0, 1'b1, 16'h0004);
      for (int o = 0; o < 64; o++) begin
         for (int f = 0; f < 4; f++) begin
            logic [31:0] w;
            logic [5:0] fn;
            fn = (f == 0) ? 6'd8 : (f == 1) ? 6'd9 : (f == 2) ? 6'd10 : 6'd0;
            w = {6'(o), 5'(f == 3 ? 5'd8 : 5'd2), 15'h1234, fn};
            slot_instr = w;
            #1;
            chk("R9 slot err", 64'(slot_err), 64'(exp_xfer(w)));
         end
      end
      in_valid = 1'b0;
      slot_instr = {6'b000010, 26'h0};
      #1;
      chk("R9 no hit", 64'(slot_err), 64'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule